// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Generator

This block sequences the horizontal and vertical regions of a display stream that a serial display host sends in video mode. Horizontal spans are counted in lane byte clock cycles, where one cycle is one byte time per lane (the per-lane bit rate divided by 8). The active span of each line and the total line length are programmed directly. The front porch is never programmed. It is whatever remains of the line after sync, back porch and active. Vertical spans are counted in whole lines.

All settings are taken into a shadow copy. While the block is stopped, the copy follows the inputs every cycle. While it runs, the copy is refreshed only on the last cycle of a frame, so a frame never mixes old and new settings. The outputs are:

- one-hot region levels for the current line position and for the current frame line;
- a line-start strobe and a sync-end strobe;
- polarity-adjusted sync levels;
- the decoded packet style;
- the pixel count per packet;
- the derived front porch;
- a flag that marks a line whose fixed spans do not fit inside the programmed line time.

Top module: `dsi_vid_timing`

## Requirements
- R1: While in reset, and while `enable_i` is low, both region buses and both strobes are zero. After reset, `cfg_err_o` is 0.
- R2: While running, every line walks through its regions in this order: HSA (bit 0) for `hsa_i` cycles, then HBP (bit 1) for `hbp_i` cycles, then active (bit 2) for `hact_i` cycles, then HFP (bit 3) until the line ends. A line lasts `hline_i` cycles. The first cycle of the run is line position 0.
- R3: `hfp_o` equals `hline_i - hsa_i - hbp_i - hact_i` when that difference is positive.
- R4: When `hsa_i + hbp_i + hact_i >= hline_i`, `cfg_err_o` is 1 and `hfp_o` is 0. Each line then lasts `hsa_i + hbp_i + hact_i` cycles and has no HFP cycle.
- R5: The lines of a frame run in this order: VSA (bit 0) for `vsa_i` lines, then VBP (bit 1) for `vbp_i` lines, then VACT (bit 2) for `vact_i` lines, then VFP (bit 3) for `vfp_i` lines. After that the next frame starts with VSA.
- R6: A `vsa_i` value above 15 gives 15 VSA lines.
- R7: `pol_i` bit 2 set makes `hsync_o` active-low and bit 1 set makes `vsync_o` active-low. A sync output is asserted during its HSA/VSA region and idles at the inactive level otherwise. Bit 0 has no effect.
- R8: `flags_i` uses bit 0 for video, bit 1 for burst and bit 2 for sync pulse. The value 3'b101 gives `mode_o` = 0 (non-burst, sync pulses). The value 3'b001 gives 1 (non-burst, sync events). Every other value gives 2 (burst).
- R9: `sync_start_o` pulses on the first cycle of every line. `sync_end_o` pulses on the first HBP cycle, but never when `mode_o` is 1.
- R10: Input changes made while running take effect only from the first cycle of the next frame.
- R11: `pkt_px_o` gives the shadowed pixel count per packet, `pkt_px_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the timing sequence |
| hsa_i | input | HW | Horizontal sync span, byte cycles |
| hbp_i | input | HW | Horizontal back porch, byte cycles |
| hact_i | input | HW | Active span, byte cycles |
| hline_i | input | HW | Total line time, byte cycles |
| vsa_i | input | VW | Vertical sync lines |
| vbp_i | input | VW | Vertical back porch lines |
| vact_i | input | VW | Active lines |
| vfp_i | input | VW | Vertical front porch lines |
| pkt_px_i | input | PW | Pixels per packet |
| pol_i | input | 3 | Sync polarity control |
| flags_i | input | 3 | Packet style flags |
| hreg_o | output | 4 | One-hot horizontal region |
| vreg_o | output | 4 | One-hot vertical region |
| sync_start_o | output | 1 | Line start strobe |
| sync_end_o | output | 1 | Sync end strobe |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| mode_o | output | 2 | Decoded packet style |
| pkt_px_o | output | PW | Shadowed pixel count |
| hfp_o | output | HW | Derived front porch |
| cfg_err_o | output | 1 | Line spans exceed line time |

## Verification
The bench builds the block with HW=8, VW=6 and PW=10. These widths keep lines and frames a few dozen cycles long, so full frames and wraps fit within a short run. With 8-bit horizontal fields, the three fixed spans can add up past the programmed line time, which exercises the error path at both the equality boundary and the value one below it. With 6-bit vertical fields, a sync count above 15 can be programmed, which exercises the clamp.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    MODE_NB_PULSE = 2'd0,
    MODE_NB_EVENT = 2'd1,
    MODE_BURST    = 2'd2
  } vmode_e;

  localparam int REG_SYNC = 0;
  localparam int REG_BP   = 1;
  localparam int REG_ACT  = 2;
  localparam int REG_FP   = 3;
  localparam int VSA_MAX  = 15;

  // flag bits: 0 video, 1 burst, 2 sync pulse
  function automatic vmode_e decode_mode(input logic [2:0] f);
    if (f == 3'b101)      return MODE_NB_PULSE;
    else if (f == 3'b001) return MODE_NB_EVENT;
    else                  return MODE_BURST;
  endfunction
endpackage

// File: rtl/vtg_cfg_shadow.sv
module vtg_cfg_shadow
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12,
  localparam int HSW = HW + 2,
  localparam int VSW = VW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [HW-1:0]  hsa_i,
  input  logic [HW-1:0]  hbp_i,
  input  logic [HW-1:0]  hact_i,
  input  logic [HW-1:0]  hline_i,
  input  logic [VW-1:0]  vsa_i,
  input  logic [VW-1:0]  vbp_i,
  input  logic [VW-1:0]  vact_i,
  input  logic [VW-1:0]  vfp_i,
  input  logic [PW-1:0]  pkt_px_i,
  input  logic [2:0]     pol_i,
  input  logic [2:0]     flags_i,
  output logic [HW-1:0]  hsa_o,
  output logic [HW-1:0]  hbp_o,
  output logic [HW-1:0]  hact_o,
  output logic [HSW-1:0] hlen_o,
  output logic [HW-1:0]  hfp_o,
  output logic [VW-1:0]  vsa_o,
  output logic [VW-1:0]  vbp_o,
  output logic [VW-1:0]  vact_o,
  output logic [VW-1:0]  vfp_o,
  output logic [VSW-1:0] flen_o,
  output logic [PW-1:0]  pkt_px_o,
  output logic           hpol_o,
  output logic           vpol_o,
  output vmode_e         mode_o,
  output logic           err_o
);
  logic [HSW-1:0] hsum, hdiff, hlen_d;
  logic [HW-1:0]  hfp_d;
  logic [VW-1:0]  vsa_c;
  logic [VSW-1:0] flen_d;
  logic           err_d;

  always_comb begin
    hsum   = HSW'(hsa_i) + HSW'(hbp_i) + HSW'(hact_i);
    err_d  = hsum >= HSW'(hline_i);
    hdiff  = HSW'(hline_i) - hsum;
    hfp_d  = err_d ? '0 : hdiff[HW-1:0];
    hlen_d = err_d ? hsum : HSW'(hline_i);
    vsa_c  = (vsa_i > VW'(VSA_MAX)) ? VW'(VSA_MAX) : vsa_i;
    flen_d = VSW'(vsa_c) + VSW'(vbp_i) + VSW'(vact_i) + VSW'(vfp_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsa_o <= '0; hbp_o <= '0; hact_o <= '0; hlen_o <= '0; hfp_o <= '0;
      vsa_o <= '0; vbp_o <= '0; vact_o <= '0; vfp_o <= '0; flen_o <= '0;
      pkt_px_o <= '0; hpol_o <= 1'b0; vpol_o <= 1'b0;
      mode_o <= MODE_BURST; err_o <= 1'b0;
    end else if (load_i) begin
      hsa_o <= hsa_i; hbp_o <= hbp_i; hact_o <= hact_i;
      hlen_o <= hlen_d; hfp_o <= hfp_d;
      vsa_o <= vsa_c; vbp_o <= vbp_i; vact_o <= vact_i; vfp_o <= vfp_i;
      flen_o <= flen_d; pkt_px_o <= pkt_px_i;
      hpol_o <= pol_i[2]; vpol_o <= pol_i[1];
      mode_o <= decode_mode(flags_i); err_o <= err_d;
    end
  end

  // R10
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(hlen_o) && $stable(hsa_o) && $stable(flen_o) && $stable(pkt_px_o)));
  // R6
  vsa_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsa_o <= VW'(VSA_MAX));
  // R4
  err_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (hlen_o == HSW'(hsa_o) + HSW'(hbp_o) + HSW'(hact_o)));
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  localparam int HSW = HW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [HW-1:0]  hsa_i,
  input  logic [HW-1:0]  hbp_i,
  input  logic [HW-1:0]  hact_i,
  input  logic [HSW-1:0] hlen_i,
  output logic [3:0]     hreg_o,
  output logic           line_first_o,
  output logic           line_last_o,
  output logic           sync_end_hit_o
);
  logic [HSW-1:0] cnt_q, b1, b2, b3, last_v;

  always_comb begin
    b1     = HSW'(hsa_i);
    b2     = b1 + HSW'(hbp_i);
    b3     = b2 + HSW'(hact_i);
    last_v = (hlen_i == '0) ? '0 : hlen_i - 1'b1;
  end

  assign line_last_o    = run_i && (cnt_q == last_v);
  assign line_first_o   = run_i && (cnt_q == '0);
  assign sync_end_hit_o = run_i && (hsa_i != '0) && (cnt_q == b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || line_last_o)   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    hreg_o = '0;
    if (run_i) begin
      if (cnt_q < b1)      hreg_o[REG_SYNC] = 1'b1;
      else if (cnt_q < b2) hreg_o[REG_BP]   = 1'b1;
      else if (cnt_q < b3) hreg_o[REG_ACT]  = 1'b1;
      else                 hreg_o[REG_FP]   = 1'b1;
    end
  end

  // R2
  hcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_v));
  // R2
  hreg_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ($countones(hreg_o) == 1));
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
#(
  parameter int VW = 11,
  localparam int VSW = VW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           line_last_i,
  input  logic [VW-1:0]  vsa_i,
  input  logic [VW-1:0]  vbp_i,
  input  logic [VW-1:0]  vact_i,
  input  logic [VSW-1:0] flen_i,
  output logic [3:0]     vreg_o,
  output logic           frame_last_o
);
  logic [VSW-1:0] cnt_q, b1, b2, b3, last_v;

  always_comb begin
    b1     = VSW'(vsa_i);
    b2     = b1 + VSW'(vbp_i);
    b3     = b2 + VSW'(vact_i);
    last_v = (flen_i == '0) ? '0 : flen_i - 1'b1;
  end

  assign frame_last_o = line_last_i && (cnt_q == last_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || frame_last_o) cnt_q <= '0;
    else if (line_last_i)            cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    vreg_o = '0;
    if (run_i) begin
      if (cnt_q < b1)      vreg_o[REG_SYNC] = 1'b1;
      else if (cnt_q < b2) vreg_o[REG_BP]   = 1'b1;
      else if (cnt_q < b3) vreg_o[REG_ACT]  = 1'b1;
      else                 vreg_o[REG_FP]   = 1'b1;
    end
  end

  // R5
  vcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_v));
  // R5
  vline_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !line_last_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [HW-1:0] hsa_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] hact_i,
  input  logic [HW-1:0] hline_i,
  input  logic [VW-1:0] vsa_i,
  input  logic [VW-1:0] vbp_i,
  input  logic [VW-1:0] vact_i,
  input  logic [VW-1:0] vfp_i,
  input  logic [PW-1:0] pkt_px_i,
  input  logic [2:0]    pol_i,
  input  logic [2:0]    flags_i,
  output logic [3:0]    hreg_o,
  output logic [3:0]    vreg_o,
  output logic          sync_start_o,
  output logic          sync_end_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [1:0]    mode_o,
  output logic [PW-1:0] pkt_px_o,
  output logic [HW-1:0] hfp_o,
  output logic          cfg_err_o
);
  localparam int HSW = HW + 2;
  localparam int VSW = VW + 2;

  logic           run_q, load, line_first, line_last, frame_last, end_hit;
  logic           hpol, vpol;
  logic [HW-1:0]  s_hsa, s_hbp, s_hact;
  logic [HSW-1:0] s_hlen;
  logic [VW-1:0]  s_vsa, s_vbp, s_vact, s_vfp;
  logic [VSW-1:0] s_flen;
  vmode_e         s_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= enable_i;
  end

  assign load = !run_q || frame_last;

  vtg_cfg_shadow #(.HW(HW), .VW(VW), .PW(PW)) u_shadow (
    .clk_i, .rst_ni, .load_i(load),
    .hsa_i, .hbp_i, .hact_i, .hline_i,
    .vsa_i, .vbp_i, .vact_i, .vfp_i,
    .pkt_px_i, .pol_i, .flags_i,
    .hsa_o(s_hsa), .hbp_o(s_hbp), .hact_o(s_hact), .hlen_o(s_hlen), .hfp_o(hfp_o),
    .vsa_o(s_vsa), .vbp_o(s_vbp), .vact_o(s_vact), .vfp_o(s_vfp), .flen_o(s_flen),
    .pkt_px_o(pkt_px_o), .hpol_o(hpol), .vpol_o(vpol), .mode_o(s_mode), .err_o(cfg_err_o)
  );

  vtg_hcount #(.HW(HW)) u_hcount (
    .clk_i, .rst_ni, .run_i(run_q),
    .hsa_i(s_hsa), .hbp_i(s_hbp), .hact_i(s_hact), .hlen_i(s_hlen),
    .hreg_o(hreg_o), .line_first_o(line_first), .line_last_o(line_last),
    .sync_end_hit_o(end_hit)
  );

  vtg_vcount #(.VW(VW)) u_vcount (
    .clk_i, .rst_ni, .run_i(run_q), .line_last_i(line_last),
    .vsa_i(s_vsa), .vbp_i(s_vbp), .vact_i(s_vact), .flen_i(s_flen),
    .vreg_o(vreg_o), .frame_last_o(frame_last)
  );

  logic unused_vfp;
  assign unused_vfp = ^s_vfp;

  assign sync_start_o = line_first;
  assign sync_end_o   = end_hit && (s_mode != MODE_NB_EVENT);
  assign hsync_o      = hreg_o[REG_SYNC] ^ hpol;
  assign vsync_o      = vreg_o[REG_SYNC] ^ vpol;
  assign mode_o       = s_mode;

  // R9
  no_end_in_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> !sync_end_o);
  // R9
  end_in_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_end_o |-> hreg_o[REG_BP]);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (hreg_o == 4'd0 && vreg_o == 4'd0 && !sync_start_o && !sync_end_o));
  // R4
  err_no_fp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !hreg_o[REG_FP]);
endmodule

// File: tb/dsi_vid_timing_bench.sv
module dsi_vid_timing_bench;
  localparam int HW = 8;
  localparam int VW = 6;
  localparam int PW = 10;

  logic clk = 1'b0, rst_ni = 1'b0, enable = 1'b0;
  logic [HW-1:0] hsa, hbp, hact, hline;
  logic [VW-1:0] vsa, vbp, vact, vfp;
  logic [PW-1:0] pkt;
  logic [2:0] pol, flags;
  logic [3:0] hreg, vreg;
  logic sync_start, sync_end, hsync, vsync, cfg_err;
  logic [1:0] mode;
  logic [PW-1:0] pkt_o;
  logic [HW-1:0] hfp;

  int n_chk = 0, n_fail = 0;

  always #5ns clk = ~clk;

  dsi_vid_timing #(.HW(HW), .VW(VW), .PW(PW)) u_dsi_vid_timing (
    .clk_i(clk), .rst_ni, .enable_i(enable),
    .hsa_i(hsa), .hbp_i(hbp), .hact_i(hact), .hline_i(hline),
    .vsa_i(vsa), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
    .pkt_px_i(pkt), .pol_i(pol), .flags_i(flags),
    .hreg_o(hreg), .vreg_o(vreg), .sync_start_o(sync_start), .sync_end_o(sync_end),
    .hsync_o(hsync), .vsync_o(vsync), .mode_o(mode), .pkt_px_o(pkt_o),
    .hfp_o(hfp), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_reg(input int p, input int a, input int b, input int c);
    if (p < a)           return 4'b0001;
    else if (p < a + b)  return 4'b0010;
    else if (p < a+b+c)  return 4'b0100;
    else                 return 4'b1000;
  endfunction

  task automatic cfg_a();
    hsa = 3; hbp = 4; hact = 10; hline = 25;
    vsa = 2; vbp = 1; vact = 3; vfp = 2;
    pkt = 640; pol = 3'b000; flags = 3'b101;
  endtask

  task automatic start_run();
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    cfg_a();
    #1ns;
    chk(hreg == 0 && vreg == 0, "R1 regions in reset", {hreg, vreg}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(hreg == 0 && vreg == 0 && !sync_start && !sync_end, "R1 idle outputs", {hreg, vreg}, 0);
    chk(cfg_err == 0, "R1 err after reset", cfg_err, 0);
  endtask

  task automatic t_hline();
    int bad = 0, ends = 0, starts = 0;
    cfg_a();
    start_run();
    for (int i = 0; i < 25; i++) begin
      if (hreg != exp_reg(i, 3, 4, 10)) bad++;
      if (sync_start) starts += (i == 0) ? 1 : 100;
      if (sync_end)   ends   += (i == 3) ? 1 : 100;
      @(negedge clk);
    end
    chk(bad == 0, "R2 region sequence", bad, 0);
    chk(sync_start && hreg == 4'b0001, "R2 line wrap at hline", {sync_start, hreg}, 5'b10001);
    chk(starts == 1 && ends == 1, "R9 strobes in pulse mode", starts * 1000 + ends, 1001);
    chk(hfp == 8 && !cfg_err, "R3 front porch", hfp, 8);
    chk(pkt_o == 640, "R11 packet pixels", pkt_o, 640);
    stop_run();
  endtask

  task automatic t_vert();
    int bad = 0;
    logic [3:0] e;
    cfg_a();
    start_run();
    for (int l = 0; l < 9; l++) begin
      e = (l == 8) ? 4'b0001 : exp_reg(l, 2, 1, 3);
      if (vreg != e || vsync != e[0]) bad++;
      repeat (25) @(negedge clk);
    end
    chk(bad == 0, "R5 vertical sequence and wrap", bad, 0);
    stop_run();
  endtask

  task automatic t_clamp();
    cfg_a();
    hsa = 1; hbp = 1; hact = 1; hline = 4;
    vsa = 20; vbp = 1; vact = 1; vfp = 1;
    start_run();
    repeat (14 * 4) @(negedge clk);
    chk(vreg == 4'b0001, "R6 line 14 still sync", vreg, 1);
    repeat (4) @(negedge clk);
    chk(vreg == 4'b0010, "R6 line 15 back porch", vreg, 2);
    stop_run();
  endtask

  task automatic t_err();
    int fp = 0;
    logic s12, s15;
    cfg_a();
    hsa = 5; hbp = 5; hact = 5; hline = 12;
    start_run();
    chk(cfg_err == 1 && hfp == 0, "R4 error flag and zero porch", {cfg_err, hfp}, 256);
    for (int i = 0; i < 16; i++) begin
      if (hreg[3]) fp++;
      if (i == 12) s12 = sync_start;
      if (i == 15) s15 = sync_start;
      @(negedge clk);
    end
    chk(fp == 0 && !s12 && s15, "R4 line stretched to 15", {fp, s12, s15}, 1);
    stop_run();
    hsa = 4; hbp = 4; hact = 4; hline = 12;
    @(negedge clk);
    chk(cfg_err == 1 && hfp == 0, "R4 equality boundary", cfg_err, 1);
    hline = 13;
    @(negedge clk);
    chk(cfg_err == 0 && hfp == 1, "R3 one cycle porch", hfp, 1);
  endtask

  task automatic t_mode();
    int ends = 0, starts = 0;
    logic [2:0] fl [6] = '{3'b101, 3'b001, 3'b011, 3'b100, 3'b111, 3'b000};
    int ex [6] = '{0, 1, 2, 2, 2, 2};
    cfg_a();
    for (int k = 0; k < 6; k++) begin
      flags = fl[k];
      @(negedge clk);
      chk(mode == ex[k], "R8 mode decode", mode, ex[k]);
    end
    flags = 3'b001;
    start_run();
    for (int i = 0; i < 50; i++) begin
      if (sync_end) ends++;
      if (sync_start) starts++;
      @(negedge clk);
    end
    chk(ends == 0 && starts == 2, "R9 event mode start only", ends * 10 + starts, 2);
    stop_run();
  endtask

  task automatic t_pol();
    cfg_a();
    pol = 3'b110;
    @(negedge clk);
    chk(hsync && vsync, "R7 active-low idle high", {hsync, vsync}, 3);
    start_run();
    chk(!hsync && !vsync, "R7 active-low asserted", {hsync, vsync}, 0);
    repeat (3) @(negedge clk);
    chk(hsync, "R7 hsync released in back porch", hsync, 1);
    stop_run();
    pol = 3'b001;
    @(negedge clk);
    chk(!hsync && !vsync, "R7 bit 0 ignored idle", {hsync, vsync}, 0);
    start_run();
    chk(hsync && vsync, "R7 bit 0 ignored asserted", {hsync, vsync}, 3);
    stop_run();
  endtask

  task automatic t_shadow();
    cfg_a();
    start_run();
    repeat (5) @(negedge clk);
    hsa = 6; pkt = 100;
    repeat (23) @(negedge clk);
    chk(hreg == 4'b0010, "R10 old sync width kept mid-frame", hreg, 2);
    chk(pkt_o == 640 && hfp == 8, "R10 shadow outputs held", pkt_o, 640);
    repeat (175) @(negedge clk);
    chk(hreg == 4'b0001, "R10 new sync width next frame", hreg, 1);
    chk(pkt_o == 100 && hfp == 5, "R11 new pixel count next frame", pkt_o, 100);
    stop_run();
  endtask

  initial begin
    #2ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_hline();
    t_vert();
    t_clamp();
    t_err();
    t_mode();
    t_pol();
    t_shadow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule